// File: doc/BRIEF.md
# Predicated Quadword Load-and-Replicate Unit

This block executes a single vector load that gathers eight 16-bit elements from consecutive memory halfwords into a 128-bit group, then copies that group into every 128-bit slice of a wide destination vector. The caller pulses `start_i` with a 32-bit instruction word, the value of the general register the word names, the stack-pointer value, and the contents of the governing predicate register. The block decodes the word, forms the effective address and walks the eight elements in ascending order. It issues one read request on a valid/ready port for each active element and waits for a 16-bit response before it moves to the next element.

Inactive elements produce no memory traffic and read as zero. When the stack pointer is the base, it is checked for 16-byte alignment before any read is issued. When the last element has been resolved, the block pulses `done_o` with the destination register index and the replicated vector. Words that do not match the encoding raise `undef_o`. A misaligned stack-pointer base raises `align_fault_o`. In both of those cases nothing is read.

Top module: `hq_ldrep`

## Requirements
- R1: The word matches only when bits 31:20 equal 101001001000 and bits 15:13 equal 001. Any other word raises `undef_o` for one cycle on the cycle after `start_i`. It issues no read and gives no `done_o`.
- R2: The effective address is the base plus the signed 4-bit field in bits 19:16 times 16, computed modulo 2^64. This gives offsets from -128 to +112.
- R3: Element e is requested at the effective address plus 2·e, and requests go out in ascending element order. A request holds its valid and address until it is accepted, and only one request is outstanding at a time.
- R4: Element e is active exactly when predicate bit 2·e is set. Odd predicate bits and predicate bits at index 16 and above have no effect.
- R5: An inactive element issues no read request, and its 16-bit lane of the result is zero.
- R6: Halfwords are assembled little-endian. Element e occupies result bits 16·e+15 down to 16·e.
- R7: The 128-bit result appears in every 128-bit slice of `done_vec_o`. The bits of the slice starting at bit 128·s equal the result for every s.
- R8: A base register number of 31 (bits 9:5) selects `sp_i` as the base. Any other number selects `base_i`.
- R9: With the stack pointer as base, at least one active element and `sp_i[3:0]` nonzero, `align_fault_o` pulses on the cycle after `start_i`, and no read or `done_o` follows. With no active element, no fault is raised and the all-zero result is delivered.
- R10: `done_o` is high for exactly one cycle, on the cycle after the last element is resolved, together with `done_dst_o` equal to bits 4:0. For a fixed predicate and fixed memory handshake timing, the cycles from start to done do not depend on addresses or loaded data.
- R11: `start_i` is ignored while `busy_o` is high. The running operation's reads, result and destination are unchanged.
- R12: While `rst` is high and on the cycle after it, `busy_o`, `mem_req_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| insn_i | input | 32 | Instruction word |
| base_i | input | 64 | Value of the general register named by bits 9:5 |
| sp_i | input | 64 | Stack-pointer value |
| pred_i | input | VLEN/8 | Governing predicate register contents |
| busy_o | output | 1 | Operation in progress |
| undef_o | output | 1 | One-cycle pulse: word is not this instruction |
| align_fault_o | output | 1 | One-cycle pulse: misaligned stack-pointer base |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | 64 | Read request byte address |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 16 | Read response halfword |
| done_o | output | 1 | One-cycle completion pulse |
| done_dst_o | output | 5 | Destination vector register index |
| done_vec_o | output | VLEN | Replicated result vector |

## Verification
If the element counter or the captured active mask is wrong, the failure shows at the ports as a missing, extra or misplaced read request within a few cycles of start. The same fault also shows as a wrong or nonzero lane in the replicated vector on the completion pulse. If the address register steps wrongly, the fault shows on the very next request, because each requested address is compared against base plus offset plus twice the element number. A state machine that stalls or finishes early shows as a wrong start-to-done cycle count or a completion pulse longer than one cycle. Sweeping all 256 masks with scrambled odd and high predicate bits exposes a wrong predicate tap on the first operation that uses it.

// File: rtl/hq_ldrep_pkg.sv
package hq_ldrep_pkg;
  localparam int AW    = 64;  // address width
  localparam int HW    = 16;  // element width
  localparam int NELEM = 8;   // elements per group
  localparam int QW    = HW * NELEM;
  localparam int RW    = 5;   // register index width

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_REQ,
    ST_RSP
  } st_e;

  typedef struct packed {
    logic          hit;
    logic [RW-1:0] rn;
    logic [RW-1:0] dst;
  } dec_t;
endpackage

// File: rtl/hq_ldrep_decode.sv
module hq_ldrep_decode
  import hq_ldrep_pkg::*;
#(
  parameter int PRED_W = 64
) (
  input  logic [31:0]       insn_i,
  input  logic [PRED_W-1:0] pred_i,
  output dec_t              dec_o,
  output logic [NELEM-1:0]  act_o,
  output logic [AW-1:0]     off_o
);
  localparam logic [11:0] OPC_HI = 12'hA48;
  localparam logic [2:0]  OPC_MID = 3'b001;
  localparam int          SCALE = $clog2(QW / 8);

  logic signed [3:0] imm;
  logic              pred_unused;

  assign imm       = insn_i[19:16];
  assign dec_o.hit = (insn_i[31:20] == OPC_HI) && (insn_i[15:13] == OPC_MID);
  assign dec_o.rn  = insn_i[9:5];
  assign dec_o.dst = insn_i[4:0];
  assign off_o     = {{(AW - 4 - SCALE){imm[3]}}, imm, {SCALE{1'b0}}};

  // Halfword element e is governed by the even predicate bit 2e.
  for (genvar e = 0; e < NELEM; e++) begin : g_tap
    assign act_o[e] = pred_i[2*e];
  end

  assign pred_unused = ^{pred_i, insn_i[12:10]};
endmodule

// File: rtl/hq_ldrep_bcast.sv
module hq_ldrep_bcast
  import hq_ldrep_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  logic [QW-1:0]   quad_i,
  output logic [VLEN-1:0] vec_o
);
  localparam int NSLICE = VLEN / QW;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign vec_o[s*QW +: QW] = quad_i;
  end
endmodule

// File: rtl/hq_ldrep_seq.sv
module hq_ldrep_seq
  import hq_ldrep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  dec_t             dec_i,
  input  logic [NELEM-1:0] act_i,
  input  logic [AW-1:0]    off_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    sp_i,
  output logic             busy_o,
  output logic             undef_o,
  output logic             fault_o,
  output logic             req_valid_o,
  output logic [AW-1:0]    req_addr_o,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  input  logic [HW-1:0]    rsp_data_i,
  output logic             done_o,
  output logic [RW-1:0]    dst_o,
  output logic [QW-1:0]    quad_o
);
  localparam int            EW     = $clog2(NELEM);
  localparam logic [EW-1:0] LAST   = EW'(NELEM - 1);
  localparam int            ALIGNW = $clog2(QW / 8);
  localparam logic [RW-1:0] SP_IDX = '1;
  localparam logic [AW-1:0] STRIDE = AW'(HW / 8);

  st_e              st_q;
  logic [EW-1:0]    elem_q;
  logic [AW-1:0]    addr_q;
  logic [NELEM-1:0] act_q;
  logic [QW-1:0]    quad_q;
  logic [RW-1:0]    dst_q;
  logic             req_q, done_q, undef_q, fault_q;

  logic             use_sp, misalign, cur_act, resolve;
  logic [AW-1:0]    ea;

  always_comb begin
    use_sp   = (dec_i.rn == SP_IDX);
    ea       = (use_sp ? sp_i : base_i) + off_i;
    misalign = use_sp && (|act_i) && (|sp_i[ALIGNW-1:0]);
    cur_act  = act_q[elem_q];
    resolve  = ((st_q == ST_STEP) && !cur_act) ||
               ((st_q == ST_RSP) && rsp_valid_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      elem_q  <= '0;
      addr_q  <= '0;
      act_q   <= '0;
      quad_q  <= '0;
      dst_q   <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!dec_i.hit) begin
              undef_q <= 1'b1;
            end else if (misalign) begin
              fault_q <= 1'b1;
              dst_q   <= dec_i.dst;
            end else begin
              st_q   <= ST_STEP;
              elem_q <= '0;
              addr_q <= ea;
              act_q  <= act_i;
              quad_q <= '0;
              dst_q  <= dec_i.dst;
            end
          end
        end
        ST_STEP: begin
          if (cur_act) begin
            req_q <= 1'b1;
            st_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready_i) begin
            req_q <= 1'b0;
            st_q  <= ST_RSP;
          end
        end
        ST_RSP: begin
          if (rsp_valid_i) begin
            quad_q[int'(elem_q)*HW +: HW] <= rsp_data_i;
            st_q <= ST_STEP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (resolve) begin
        if (elem_q == LAST) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          elem_q <= elem_q + 1'b1;
          addr_q <= addr_q + STRIDE;
        end
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign undef_o     = undef_q;
  assign fault_o     = fault_q;
  assign req_valid_o = req_q;
  assign req_addr_o  = addr_q;
  assign done_o      = done_q;
  assign dst_o       = dst_q;
  assign quad_o      = quad_q;
endmodule

// File: rtl/hq_ldrep.sv
module hq_ldrep
  import hq_ldrep_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [31:0]         insn_i,
  input  logic [63:0]         base_i,
  input  logic [63:0]         sp_i,
  input  logic [VLEN/8-1:0]   pred_i,
  output logic                busy_o,
  output logic                undef_o,
  output logic                align_fault_o,
  output logic                mem_req_valid_o,
  output logic [63:0]         mem_req_addr_o,
  input  logic                mem_req_ready_i,
  input  logic                mem_rsp_valid_i,
  input  logic [15:0]         mem_rsp_data_i,
  output logic                done_o,
  output logic [4:0]          done_dst_o,
  output logic [VLEN-1:0]     done_vec_o
);
  localparam int PRED_W = VLEN / 8;

  dec_t             dec;
  logic [NELEM-1:0] act;
  logic [AW-1:0]    off;
  logic [QW-1:0]    quad;

  hq_ldrep_decode #(.PRED_W(PRED_W)) u_dec (
    .insn_i (insn_i),
    .pred_i (pred_i),
    .dec_o  (dec),
    .act_o  (act),
    .off_o  (off)
  );

  hq_ldrep_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dec_i       (dec),
    .act_i       (act),
    .off_i       (off),
    .base_i      (base_i),
    .sp_i        (sp_i),
    .busy_o      (busy_o),
    .undef_o     (undef_o),
    .fault_o     (align_fault_o),
    .req_valid_o (mem_req_valid_o),
    .req_addr_o  (mem_req_addr_o),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_data_i  (mem_rsp_data_i),
    .done_o      (done_o),
    .dst_o       (done_dst_o),
    .quad_o      (quad)
  );

  hq_ldrep_bcast #(.VLEN(VLEN)) u_bc (
    .quad_i (quad),
    .vec_o  (done_vec_o)
  );
endmodule

// File: rtl/hq_ldrep_chk.sv
module hq_ldrep_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy_o,
  input logic        undef_o,
  input logic        align_fault_o,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [63:0] mem_req_addr_o,
  input logic        done_o,
  input logic [4:0]  done_dst_o
);
  // R12: quiet during and right after reset
  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> (!busy_o && !mem_req_valid_o && !done_o));

  // R3: a pending request holds valid and address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R1: undefined word leaves the block idle
  p_undef_idle_r1: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (!busy_o && !done_o && !mem_req_valid_o));

  // R9: alignment fault issues nothing
  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    align_fault_o |-> (!busy_o && !mem_req_valid_o && !done_o));

  // R5: requests only inside an operation
  p_req_in_op_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |-> busy_o);

  // R11: destination cannot change mid-operation
  p_dst_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(done_dst_o));
endmodule

bind hq_ldrep hq_ldrep_chk u_chk (.*);

// File: tb/test_hq_ldrep.sv
`timescale 1ns/1ps
module test_hq_ldrep;
  localparam int VL  = 256;
  localparam int PW  = VL / 8;
  localparam int NSL = VL / 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [31:0]   insn_i = '0;
  logic [63:0]   base_i = '0;
  logic [63:0]   sp_i = '0;
  logic [PW-1:0] pred_i = '0;
  logic          busy_o, undef_o, align_fault_o, mem_req_valid_o, done_o;
  logic [63:0]   mem_req_addr_o;
  logic          mem_req_ready_i = 1'b1;
  logic          mem_rsp_valid_i = 1'b0;
  logic [15:0]   mem_rsp_data_i = '0;
  logic [4:0]    done_dst_o;
  logic [VL-1:0] done_vec_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_n = 0;
  logic [63:0] rd_addr [16];
  bit  stall_mode = 0;
  bit  inject = 0;
  int  last_lat = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hq_ldrep #(.VLEN(VL)) i_hq_ldrep (
    .clk(clk), .rst(rst), .start_i(start_i), .insn_i(insn_i),
    .base_i(base_i), .sp_i(sp_i), .pred_i(pred_i),
    .busy_o(busy_o), .undef_o(undef_o), .align_fault_o(align_fault_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o),
    .done_dst_o(done_dst_o), .done_vec_o(done_vec_o)
  );

  function automatic logic [15:0] mdata(input logic [63:0] a);
    return (a[15:0] * 16'h9E37) ^ a[31:16] ^ a[63:48] ^ 16'hC3A5;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] imm, input logic [4:0] rn,
                                     input logic [4:0] dst);
    return {12'hA48, imm, 3'b001, 3'd2, rn, dst};
  endfunction

  function automatic logic [PW-1:0] mkpred(input logic [7:0] m, input logic [7:0] junk,
                                           input bit high);
    logic [PW-1:0] p;
    p = high ? '1 : '0;
    for (int e = 0; e < 8; e++) begin
      p[2*e]   = m[e];
      p[2*e+1] = junk[e];
    end
    return p;
  endfunction

  // memory model: one response, one cycle after each accepted request
  initial begin
    bit pend;
    logic [15:0] pdata;
    pend = 0;
    pdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = pend;
      mem_rsp_data_i  = pend ? pdata : 16'h0;
      pend = 0;
      mem_req_ready_i = stall_mode ? ((cyc % 3) != 1) : 1'b1;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (rd_n < 16) rd_addr[rd_n] = mem_req_addr_o;
        rd_n++;
        pend = 1;
        pdata = mdata(mem_req_addr_o);
      end
    end
  end

  task automatic chk(input bit c, input string what, input logic [127:0] got,
                     input logic [127:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s got %h exp %h", what, got, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] insn, input logic [63:0] base, input logic [63:0] sp,
                        input logic [PW-1:0] pred, output int lat, output int kind,
                        output logic [VL-1:0] vg, output logic [4:0] dg,
                        output bit pulse_ok, output int rd_after);
    @(negedge clk);
    rd_n = 0;
    insn_i = insn; base_i = base; sp_i = sp; pred_i = pred;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    kind = 3;
    vg = '0;
    dg = '0;
    for (int i = 0; i < 400; i++) begin
      if (done_o)        begin kind = 0; break; end
      if (undef_o)       begin kind = 1; break; end
      if (align_fault_o) begin kind = 2; break; end
      if (inject && i == 2) begin
        start_i = 1'b1;
        insn_i = mk(4'h7, 5'd2, 5'd9);
        base_i = 64'h7777_0000;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    vg = done_vec_o;
    dg = done_dst_o;
    @(negedge clk);
    pulse_ok = !done_o && !undef_o && !align_fault_o;
    repeat (3) begin
      @(negedge clk);
      if (done_o || busy_o) pulse_ok = 0;
    end
    rd_after = rd_n;
  endtask

  task automatic check_op(input string tag, input logic [31:0] insn, input logic [63:0] base,
                          input logic [63:0] sp, input logic [PW-1:0] pred);
    bit hit, addr_ok, vec_ok, pulse_ok;
    logic [4:0] rn, dst, dg;
    logic [63:0] ea, bsel, badg, bade;
    logic [7:0] act;
    logic [127:0] expq, badv;
    logic [VL-1:0] vg;
    int expk, nact, k, lat, kind, rd_after;
    hit = (insn[31:20] == 12'hA48) && (insn[15:13] == 3'b001);
    rn = insn[9:5];
    dst = insn[4:0];
    for (int e = 0; e < 8; e++) act[e] = pred[2*e];
    bsel = (rn == 5'd31) ? sp : base;
    ea = bsel + {{56{insn[19]}}, insn[19:16], 4'b0000};
    expk = !hit ? 1 : ((rn == 5'd31) && (act != 0) && (sp[3:0] != 0)) ? 2 : 0;
    nact = 0;
    expq = '0;
    for (int e = 0; e < 8; e++)
      if (act[e]) begin
        expq[16*e +: 16] = mdata(ea + 64'(2*e));
        nact++;
      end
    run_op(insn, base, sp, pred, lat, kind, vg, dg, pulse_ok, rd_after);
    last_lat = lat;
    chk(kind == expk, {tag, " R1 R9 outcome kind"}, 128'(kind), 128'(expk));
    chk(pulse_ok, {tag, " R10 single pulse then idle"}, 128'(pulse_ok), 128'(1));
    if (expk != 0) begin
      chk(rd_after == 0, {tag, " R1 R9 no reads"}, 128'(rd_after), 128'(0));
    end else begin
      chk(rd_after == nact, {tag, " R4 R5 read count"}, 128'(rd_after), 128'(nact));
      addr_ok = 1; badg = '0; bade = '0; k = 0;
      for (int e = 0; e < 8; e++)
        if (act[e]) begin
          if (k < 16 && rd_addr[k] !== ea + 64'(2*e) && addr_ok) begin
            addr_ok = 0; badg = rd_addr[k]; bade = ea + 64'(2*e);
          end
          k++;
        end
      chk(addr_ok, {tag, " R2 R3 R8 request address"}, 128'(badg), 128'(bade));
      vec_ok = 1; badv = expq;
      for (int s = 0; s < NSL; s++)
        if (vg[s*128 +: 128] !== expq && vec_ok) begin
          vec_ok = 0; badv = vg[s*128 +: 128];
        end
      chk(vec_ok, {tag, " R5 R6 R7 replicated result"}, badv, expq);
      chk(dg == dst, {tag, " R10 destination index"}, 128'(dg), 128'(dst));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete got timeout exp finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int la, lb;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy_o && !mem_req_valid_o && !done_o, "R12 outputs in reset",
        128'({busy_o, mem_req_valid_o, done_o}), 128'(0));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !mem_req_valid_o && !done_o && !undef_o, "R12 idle after reset",
        128'({busy_o, mem_req_valid_o, done_o, undef_o}), 128'(0));

    // R4 R5 R6 R7: every active mask, scrambled odd and high predicate bits
    for (int m = 0; m < 256; m++)
      check_op("mask", mk(4'd3, 5'd5, 5'(m)), 64'h1000_0000_0000_4000 + 64'(m * 96),
               64'hDEAD_0000_0000_0008, mkpred(8'(m), 8'(m * 37 + 11), m[0]));

    // R4: odd and high bits alone select nothing
    check_op("odd bits only R4", mk(4'd0, 5'd1, 5'd4), 64'h2000, 64'h0,
             mkpred(8'h00, 8'hFF, 1'b1));

    // R2: every immediate value, including wrap at the top of the address space
    for (int i = 0; i < 16; i++) begin
      check_op("imm R2", mk(4'(i), 5'd7, 5'd3), 64'h0000_0000_0000_2000,
               64'h0, mkpred(8'hFF, 8'h00, 1'b0));
      check_op("imm wrap R2", mk(4'(i), 5'd7, 5'd3), 64'hFFFF_FFFF_FFFF_FFF8,
               64'h0, mkpred(8'hA5, 8'h00, 1'b0));
    end

    // R8: register 31 selects the stack pointer
    check_op("sp base R8", mk(4'hE, 5'd31, 5'd31), 64'h5555_5555_5555_5555,
             64'h8000_0000_0000_1230, mkpred(8'hFF, 8'h00, 1'b0));
    check_op("gpr base R8", mk(4'h2, 5'd30, 5'd1), 64'h0000_0000_0000_3003,
             64'h8000_0000_0000_1230, mkpred(8'h3C, 8'h00, 1'b0));

    // R9: misaligned stack pointer, with and without active elements
    for (int b = 1; b < 16; b++)
      check_op("sp align R9", mk(4'h1, 5'd31, 5'd6), 64'h0, 64'h0000_0000_0000_4000 + 64'(b),
               mkpred(8'(1 << (b % 8)), 8'h00, 1'b0));
    check_op("sp align none active R9", mk(4'h1, 5'd31, 5'd6), 64'h0,
             64'h0000_0000_0000_4007, mkpred(8'h00, 8'hFF, 1'b1));

    // R1: each fixed opcode bit flipped
    for (int b = 13; b < 32; b++)
      if (b >= 20 || b <= 15)
        check_op("undef R1", mk(4'h0, 5'd2, 5'd2) ^ (32'h1 << b), 64'h1000, 64'h0,
                 mkpred(8'hFF, 8'h00, 1'b0));

    // R3: back-pressure on the request port
    stall_mode = 1;
    for (int m = 1; m < 256; m += 17)
      check_op("stall R3", mk(4'h9, 5'd4, 5'd12), 64'h0000_0100_0000_0000 + 64'(m),
               64'h0, mkpred(8'(m), 8'h55, 1'b0));
    stall_mode = 0;

    // R10: latency independent of address and data
    check_op("latency A R10", mk(4'h0, 5'd3, 5'd8), 64'h0000_0000_0000_1000, 64'h0,
             mkpred(8'h6B, 8'h00, 1'b0));
    la = last_lat;
    check_op("latency B R10", mk(4'h8, 5'd3, 5'd8), 64'hFFFF_0000_1234_5670, 64'h0,
             mkpred(8'h6B, 8'hFF, 1'b1));
    lb = last_lat;
    chk(la == lb, "R10 latency independent of data", 128'(lb), 128'(la));

    // R11: start while busy is ignored
    inject = 1;
    check_op("busy start R11", mk(4'h5, 5'd6, 5'd20), 64'h0000_0000_0009_0000, 64'h0,
             mkpred(8'hF0, 8'h00, 1'b0));
    check_op("busy start sparse R11", mk(4'hC, 5'd6, 5'd21), 64'h0000_0000_0009_0000, 64'h0,
             mkpred(8'h81, 8'h00, 1'b0));
    inject = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule